// File: doc/BRIEF.md
# Byte-Stream Memory Access Monitor

This block lets a host reach a word-addressed storage array over a byte-wide serial link. It sits behind the receive and transmit byte ports of a UART. It turns a short command stream into storage reads and writes. The UART bit engine and its baud timing live elsewhere. Each command starts with one opcode byte and then carries a 32-bit address as four bytes, lowest byte first. A write command then carries four data bytes, also lowest byte first. The word is committed to storage only once its last byte has arrived.

A read answers with the four bytes of the stored word, lowest byte first. Every command ends with one status byte. The status reports one of these outcomes: success, an unknown opcode, an address outside the storage, or an attempt to change a protected word. While the response is going out, the receive side is closed, so commands never overlap.

If a command stops partway through, a host-programmable idle limit lets the block abandon it and wait for a fresh opcode.

Top module: `uart_mem_monitor`

## Requirements
- R1: After reset, `rx_ready` is 1 and `tx_valid` is 0.
- R2: Opcode 0x00 starts a read and 0x01 starts a write. Any other opcode byte is answered at once with the single status byte 0x01, and the block then waits for a new opcode.
- R3: The four bytes after the opcode form a 32-bit address, first byte in bits 7:0 and last byte in bits 31:24. All 32 bits are used in the mapping check.
- R4: A write takes four data bytes, first byte in bits 7:0. Storage changes only when the fourth data byte is accepted. A successful write answers with the status byte 0x00 alone.
- R5: A read of a mapped address answers with five bytes: the stored word from bits 7:0 up to bits 31:24, then status 0x00.
- R6: An address of 256 or more is unmapped. Any command to it answers with status 0x02 alone, and no word is stored.
- R7: Words 0 to 15 are protected. A write to one of them answers 0x03 and leaves the word unchanged. For an address that is both unmapped and low, 0x02 wins.
- R8: While a response is pending or being sent, `rx_ready` is 0. After the last response byte has gone out, the block returns to waiting for an opcode.
- R9: A response byte offered with `tx_valid` stays valid and unchanged until `tx_ready` takes it.
- R10: If a partly received command sees `idle_limit` consecutive cycles with no byte accepted, it is dropped without any response. An `idle_limit` of 0 turns this off.
- R11: After reset, word i holds the bytes 0x3C, ~i, i, 0xC3, from bits 7:0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_limit | input | TO_W | Idle cycles allowed inside a command (0 = no limit) |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the response byte |

## Verification
The assertions check four things on every cycle: the receive side is closed while a response is offered, a stalled response byte is held steady, the block returns to opcode wait when a response ends, and a bad opcode is answered on the next cycle. Some behaviours can only be shown by the bench scenarios, because they depend on the data path. These are the byte order of addresses and words, the status priority, protected and unmapped writes that leave storage unchanged, partial writes that are never committed, and the exact cycle at which an idle command is dropped. For these the bench compares against a queue-based model on every clock.

// File: rtl/uart_mem_monitor.sv
module uart_mem_monitor #(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 256,
  parameter int RO_WORDS = 16,
  parameter int TO_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] idle_limit,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  input  logic            tx_ready
);
  localparam int NB = DATA_W / 8;
  localparam int AW = $clog2(DEPTH);
  localparam int RW = DATA_W + 8;
  localparam int BW = $clog2(NB + 2);
  localparam int IW = $clog2((NB > 4 ? NB : 4) + 1);
  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_BADOP = 8'h01;
  localparam logic [7:0] ST_UNMAP = 8'h02;
  localparam logic [7:0] ST_RO    = 8'h03;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_RD, S_SEND} st_t;

  st_t               st;
  logic              op;
  logic [IW-1:0]     idx;
  logic [31:0]       addr;
  logic [DATA_W-9:0] wbuf;
  logic [RW-1:0]     resp;
  logic [BW-1:0]     left;
  logic [TO_W-1:0]   cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  logic              rx_fire, timeout, we;
  logic [31:0]       addr_full;
  logic [DATA_W-1:0] word_full;
  logic [7:0]        wr_status;

  assign rx_ready  = (st == S_IDLE) || (st == S_ADDR) || (st == S_DATA);
  assign rx_fire   = rx_valid && rx_ready;
  assign tx_valid  = (st == S_SEND);
  assign tx_data   = resp[7:0];
  assign addr_full = {rx_data, addr[31:8]};
  assign word_full = {rx_data, wbuf};
  assign wr_status = (addr >= 32'(DEPTH))   ? ST_UNMAP :
                     (addr <  32'(RO_WORDS)) ? ST_RO    : ST_OK;
  assign timeout   = ((st == S_ADDR) || (st == S_DATA)) && !rx_fire &&
                     (idle_limit != '0) && (cnt == idle_limit - TO_W'(1));
  assign we        = (st == S_DATA) && rx_fire && (idx == IW'(NB - 1)) &&
                     (wr_status == ST_OK);

  function automatic logic [DATA_W-1:0] init_word(input int i);
    logic [7:0] b;
    b = i[7:0];
    return DATA_W'({8'hC3, b, ~b, 8'h3C});
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
    end else if (we) begin
      mem[addr[AW-1:0]] <= word_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      op   <= 1'b0;
      idx  <= '0;
      addr <= '0;
      wbuf <= '0;
      resp <= '0;
      left <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx_fire) begin
          if (rx_data <= 8'd1) begin
            op  <= rx_data[0];
            idx <= '0;
            cnt <= '0;
            st  <= S_ADDR;
          end else begin
            resp <= RW'(ST_BADOP);
            left <= BW'(1);
            st   <= S_SEND;
          end
        end
        S_ADDR, S_DATA: begin
          if (rx_fire) begin
            cnt <= '0;
            idx <= idx + IW'(1);
            if (st == S_ADDR) begin
              addr <= addr_full;
              if (idx == IW'(3)) begin
                idx <= '0;
                if (op) st <= S_DATA;
                else if (addr_full < 32'(DEPTH)) st <= S_RD;
                else begin
                  resp <= RW'(ST_UNMAP);
                  left <= BW'(1);
                  st   <= S_SEND;
                end
              end
            end else begin
              wbuf <= word_full[DATA_W-1:8];
              if (idx == IW'(NB - 1)) begin
                resp <= RW'(wr_status);
                left <= BW'(1);
                st   <= S_SEND;
              end
            end
          end else if (timeout) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + TO_W'(1);
          end
        end
        S_RD: begin
          resp <= {ST_OK, mem[addr[AW-1:0]]};
          left <= BW'(NB + 1);
          st   <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          resp <= resp >> 8;
          left <= left - BW'(1);
          if (left == BW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module uart_mem_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       in_idle
);
  // R2
  bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && rx_valid && rx_ready && rx_data > 8'd1) |=> (tx_valid && tx_data == 8'h01));
  // R8
  rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);
  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> (rx_ready && in_idle));
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind uart_mem_monitor uart_mem_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .in_idle(st == S_IDLE)
);

// File: tb/uart_mem_monitor_bench.sv
module uart_mem_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] idle_limit;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_ready = 1'b1;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;

  int    errors = 0, checks = 0, cyc = 0;
  string cur_req = "R1";
  bit    stall = 0;
  logic [7:0] got[$];
  logic [7:0] eq[$];

  uart_mem_monitor u_uart_mem_monitor (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    tx_ready <= stall ? (cyc % 3 == 0) : 1'b1;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_w(input int i);
    logic [7:0] b;
    b = i[7:0];
    return {8'hC3, b, ~b, 8'h3C};
  endfunction

  // reference model
  logic [31:0] mm[256];
  int ph, idx, cnt;
  bit mop;
  logic [31:0] ma, mw;
  logic [7:0] txq[$];

  always @(posedge clk) begin : model
    bit acc;
    logic [7:0] s8;
    if (!rst_n) begin
      ph = 0; idx = 0; cnt = 0; txq.delete();
      for (int i = 0; i < 256; i++) mm[i] = init_w(i);
    end else begin
      acc = rx_valid && (ph <= 2);
      case (ph)
        0: if (acc) begin
          if (rx_data <= 8'd1) begin
            mop = rx_data[0]; ph = 1; idx = 0; cnt = 0; ma = 0;
          end else begin
            txq.push_back(8'h01); ph = 4;
          end
        end
        1, 2: if (acc) begin
          cnt = 0;
          if (ph == 1) begin
            ma[8*idx +: 8] = rx_data; idx++;
            if (idx == 4) begin
              idx = 0; mw = 0;
              if (mop) ph = 2;
              else if (ma >= 256) begin txq.push_back(8'h02); ph = 4; end
              else ph = 3;
            end
          end else begin
            mw[8*idx +: 8] = rx_data; idx++;
            if (idx == 4) begin
              if (ma >= 256) s8 = 8'h02;
              else if (ma < 16) s8 = 8'h03;
              else begin s8 = 8'h00; mm[ma[7:0]] = mw; end
              txq.push_back(s8); ph = 4;
            end
          end
        end else if (idle_limit != 0 && cnt == int'(idle_limit) - 1) begin
          ph = 0; cnt = 0;
        end else cnt++;
        3: begin
          for (int k = 0; k < 4; k++) txq.push_back(mm[ma[7:0]][8*k +: 8]);
          txq.push_back(8'h00); ph = 4;
        end
        4: if (tx_ready) begin
          void'(txq.pop_front());
          if (txq.size() == 0) ph = 0;
        end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(rx_ready === (ph <= 2), cur_req, "rx_ready vs model", rx_ready, ph <= 2);
    chk(tx_valid === (ph == 4), cur_req, "tx_valid vs model", tx_valid, ph == 4);
    if (ph == 4 && txq.size() > 0)
      chk(tx_data === txq[0], cur_req, "tx_data vs model", tx_data, txq[0]);
    if (tx_valid && tx_ready) got.push_back(tx_data);
  end

  task automatic send_byte(input logic [7:0] b, input int gap = 0);
    repeat (gap) @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic cmd_read(input logic [31:0] a, input int gap = 0);
    send_byte(8'h00);
    for (int i = 0; i < 4; i++) send_byte(a[8*i +: 8], gap);
  endtask

  task automatic cmd_write(input logic [31:0] a, input logic [31:0] d, input int gap = 0);
    send_byte(8'h01);
    for (int i = 0; i < 4; i++) send_byte(a[8*i +: 8], gap);
    for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8], gap);
  endtask

  task automatic exp_word(input logic [31:0] w);
    eq.delete();
    for (int i = 0; i < 4; i++) eq.push_back(w[8*i +: 8]);
    eq.push_back(8'h00);
  endtask

  task automatic exp_status(input logic [7:0] s);
    eq.delete();
    eq.push_back(s);
  endtask

  task automatic expect_resp(input string req);
    int t;
    t = 0;
    while (got.size() < eq.size() && t < 300) begin @(negedge clk); #1; t++; end
    repeat (3) @(negedge clk);
    #1;
    chk(got.size() == eq.size(), req, "response length", got.size(), eq.size());
    for (int i = 0; i < eq.size(); i++)
      if (i < got.size())
        chk(got[i] === eq[i], req, $sformatf("response byte %0d", i), got[i], eq[i]);
    got.delete();
  endtask

  initial begin
    rx_valid = 1'b0; rx_data = 8'h00; idle_limit = 16'(LIMIT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rx_ready === 1'b1, "R1", "rx_ready after reset", rx_ready, 1);
    chk(tx_valid === 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    @(negedge clk);

    cur_req = "R11";
    cmd_read(32'd3); exp_word(init_w(3)); expect_resp("R11");

    cur_req = "R4";
    cmd_write(32'h20, 32'h11223344); exp_status(8'h00); expect_resp("R4");
    cur_req = "R5";
    cmd_read(32'h20); exp_word(32'h11223344); expect_resp("R5");

    cur_req = "R7";
    cmd_write(32'd5, 32'hDEADBEEF); exp_status(8'h03); expect_resp("R7");
    cmd_read(32'd5); exp_word(init_w(5)); expect_resp("R7");

    cur_req = "R6";
    cmd_write(32'h100, 32'h0BADF00D); exp_status(8'h02); expect_resp("R6");
    cmd_write(32'h120, 32'h55AA55AA); exp_status(8'h02); expect_resp("R6");
    cmd_read(32'h20); exp_word(32'h11223344); expect_resp("R6");
    cmd_write(32'h8000_0003, 32'h1); exp_status(8'h02); expect_resp("R7");

    cur_req = "R3";
    cmd_read(32'h0100_0010); exp_status(8'h02); expect_resp("R3");
    cmd_write(32'h0000_00A7, 32'hA1B2C3D4); exp_status(8'h00); expect_resp("R3");
    cmd_read(32'h0000_00A7); exp_word(32'hA1B2C3D4); expect_resp("R3");

    cur_req = "R2";
    send_byte(8'h07); exp_status(8'h01); expect_resp("R2");
    send_byte(8'hFF); exp_status(8'h01); expect_resp("R2");
    cmd_read(32'h20); exp_word(32'h11223344); expect_resp("R2");

    cur_req = "R10";
    send_byte(8'h01); send_byte(8'h40); send_byte(8'h00);
    repeat (LIMIT + 10) @(negedge clk);
    #1;
    chk(got.size() == 0, "R10", "no response after drop", got.size(), 0);
    chk(rx_ready === 1'b1, "R10", "idle after drop", rx_ready, 1);
    cmd_read(32'h40); exp_word(init_w(64)); expect_resp("R10");

    cur_req = "R4";
    send_byte(8'h01);
    for (int i = 0; i < 4; i++) send_byte(i == 0 ? 8'h41 : 8'h00);
    send_byte(8'h99); send_byte(8'h88);
    repeat (LIMIT + 10) @(negedge clk);
    cmd_read(32'h41); exp_word(init_w(65)); expect_resp("R4");

    cur_req = "R10";
    cmd_write(32'h30, 32'hCAFEF00D, LIMIT - 3); exp_status(8'h00); expect_resp("R10");
    cmd_read(32'h30); exp_word(32'hCAFEF00D); expect_resp("R10");

    idle_limit = 16'd0;
    send_byte(8'h00); send_byte(8'h21);
    repeat (60) @(negedge clk);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    exp_word(init_w(33)); expect_resp("R10");
    idle_limit = 16'(LIMIT);

    cur_req = "R9";
    stall = 1;
    cmd_read(32'h30);
    while (!tx_valid) begin @(negedge clk); #1; end
    chk(rx_ready === 1'b0, "R8", "rx closed during response", rx_ready, 0);
    rx_data = 8'h09; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    exp_word(32'hCAFEF00D); eq.push_back(8'h01); expect_resp("R8");
    stall = 0;

    repeat (5) @(negedge clk);
    summary();
  end
endmodule